// File: doc/BRIEF.md
# Successive-Approximation Converter Scan Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter that reads four analog inputs through one multiplexer. It selects the multiplexer channel, presents a trial code to the converter's DAC, samples the comparator decision, and settles the result one bit per clock, from the most significant bit down. The number of bits per conversion can be set anywhere from 2 to 10. A conversion therefore takes fewer cycles at low resolution, and the sample rate rises.

Software uses a small register port to configure the block. It picks the channels to convert, the resolution, single-pass or repeating scan, power-down and interrupt enable. It then issues start and stop commands and reads back one result per channel and a sticky completion flag. The flag drives the interrupt output when the interrupt is enabled.

The controller has four states. `ST_OFF` means powered down. `ST_IDLE` waits for a start command. `ST_SAMPLE` is one cycle in which the selected input is acquired. `ST_TRIAL` runs one cycle per bit.

The transitions are:
- reset → `ST_IDLE`
- any state → `ST_OFF` when power-down is set
- `ST_OFF` → `ST_IDLE` when power-down clears
- `ST_IDLE` → `ST_SAMPLE` on an accepted start
- `ST_SAMPLE` → `ST_TRIAL` on the next cycle
- `ST_TRIAL` → `ST_TRIAL` while bits remain
- `ST_TRIAL` → `ST_SAMPLE` after the last bit, when another enabled channel follows or a repeating scan restarts
- `ST_TRIAL` → `ST_IDLE` after the last bit of a single pass
- `ST_SAMPLE` or `ST_TRIAL` → `ST_IDLE` on a stop command

Top module: `adc_scan_seq`

## Requirements
- R1: Channel select `ana_sel` carries the channel being converted. The value converted for channel k is readable at register address 4+k, in bits [9:0].
- R2: The resolution field is control bits [7:4] and reset to 10. A written value below 2 is stored as 2, and one above 10 is stored as 10; the stored value reads back.
- R3: Each conversion of N bits takes exactly 1+N cycles: one sample cycle and N trial cycles. Status bit 1 (busy) stays high for that many cycles per converted channel in a pass.
- R4: In each trial cycle `dac_code` equals the bits settled so far with the current trial bit set. The bit is kept when `cmp_ge` is 1, meaning input ≥ trial level, and cleared otherwise. The N-bit result is therefore the input truncated to its top N bits.
- R5: Results are stored left-justified in 10 bits, with the 10−N low bits zero.
- R6: The channel enable mask is control bits [3:0]. Enabled channels are converted in ascending order, and disabled ones are skipped without spending any cycle; their results keep their previous value.
- R7: With control bit 8 (repeat) clear, a start (command register address 1, bit 0) converts each enabled channel once and returns to idle.
- R8: With control bit 8 set, the scan restarts at the lowest enabled channel after each pass. A stop (command bit 1) returns the block to idle on the next cycle.
- R9: Control bit 9 (power-down) halts any conversion within two cycles of being written, drives `ana_en` low, and causes starts to be ignored. Clearing it brings `ana_en` back high.
- R10: A start with an empty enable mask is ignored and the block stays idle.
- R11: Status bit 0 (done) is set at the end of every pass and is cleared by writing 1 to it at address 2. When the set and the clear land on the same cycle, the flag stays set. `irq` equals done AND control bit 10 (interrupt enable).
- R12: After reset the control register reads 0x00A0, the status register reads 0, `ana_en` is 1, `irq` is 0 and `dac_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 command, 2 status, 4-7 results) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt: done flag gated by interrupt enable |
| ana_en | output | 1 | Analog front-end enable, low in power-down |
| ana_sel | output | 2 | Input multiplexer channel select |
| dac_code | output | 10 | Trial code to the DAC, zero outside trial cycles |
| cmp_ge | input | 1 | Comparator: 1 when input is at or above the trial level |

## Verification
The end of a pass can set the done flag on the same clock edge that a software write-one-to-clear arrives. The bench starts a single-channel, four-bit scan and counts edges so that its clear write is sampled on the exact edge of the final trial. It then expects done and `irq` still high, while a plain clear afterwards must drop both. A second contention, a stop or power-down arriving while a conversion is in flight, is provoked mid-scan and judged by busy and `ana_en` falling within the stated cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL
    } seq_state_t;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CMD  = 3'd1;
    localparam logic [2:0] ADDR_STAT = 3'd2;

endpackage

// File: rtl/adc_chan_next.sv
module adc_chan_next #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW:0]    lo,
    output logic           found,
    output logic [CW-1:0]  idx
);

    // lowest enabled channel at or above lo
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && ((CW+1)'(i) >= lo)) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/adc_sar_step.sv
module adc_sar_step #(
    parameter int MAXW = 10,
    parameter int RW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            cmp_ge,
    input  logic [RW-1:0]   res,
    output logic [MAXW-1:0] trial_code,
    output logic [MAXW-1:0] acc_next,
    output logic            last
);

    localparam int PW = $clog2(MAXW);

    logic [MAXW-1:0] acc;
    logic [PW-1:0]   pos;
    logic [MAXW-1:0] trial_bit;

    always_comb begin
        trial_bit  = MAXW'(1) << pos;
        trial_code = acc | trial_bit;
        acc_next   = cmp_ge ? trial_code : acc;
        last       = (pos == PW'(MAXW - int'(res)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            pos <= PW'(MAXW - 1);
        end else if (load) begin
            acc <= '0;
            pos <= PW'(MAXW - 1);
        end else if (step && !last) begin
            acc <= acc_next;
            pos <= pos - 1'b1;
        end
    end

    // R4: a trial never reaches below the least significant bit of the resolution
    assert_trial_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (int'(pos) >= MAXW - int'(res)));

    // R4: the bit under trial has not been settled yet
    assert_trial_bit_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ((acc & trial_bit) == '0));

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int MAXW = 10,
    parameter int MINW = 2,
    parameter int DW   = 16,
    parameter int AW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq,
    output logic            ana_en,
    output logic [$clog2(NCH)-1:0] ana_sel,
    output logic [MAXW-1:0] dac_code,
    input  logic            cmp_ge
);

    localparam int CW       = $clog2(NCH);
    localparam int RW       = $clog2(MAXW + 1);
    localparam int RES_LSB  = NCH;
    localparam int CONT_BIT = RES_LSB + RW;
    localparam int PD_BIT   = CONT_BIT + 1;
    localparam int IE_BIT   = CONT_BIT + 2;

    function automatic logic [RW-1:0] clamp_res(input logic [RW-1:0] r);
        if (int'(r) < MINW)      return RW'(MINW);
        else if (int'(r) > MAXW) return RW'(MAXW);
        else                     return r;
    endfunction

    seq_state_t state, state_nx;
    logic [CW-1:0]   ch, ch_nx;
    logic [NCH-1:0]  en_q, scan_mask;
    logic [RW-1:0]   res_q, scan_res;
    logic            cont_q, pd_q, ie_q, scan_cont, done_q;
    logic            start_req, stop_req, clr_req, ctrl_wr;
    logic            accept, done_set, res_we, load, step, busy;
    logic            first_found, nxt_found, last;
    logic [CW-1:0]   first_idx, nxt_idx;
    logic [MAXW-1:0] trial_code, acc_next;
    logic [MAXW-1:0] res_q_arr [NCH];
    wire             unused_wdata = ^reg_wdata[DW-1:IE_BIT+1];

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign start_req = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[0];
    assign stop_req  = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[1];
    assign clr_req   = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

    adc_chan_next #(.NCH(NCH), .CW(CW)) u_first (
        .mask  ((state == ST_IDLE) ? en_q : scan_mask),
        .lo    ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    adc_chan_next #(.NCH(NCH), .CW(CW)) u_next (
        .mask  (scan_mask),
        .lo    ({1'b0, ch} + 1'b1),
        .found (nxt_found),
        .idx   (nxt_idx)
    );

    adc_sar_step #(.MAXW(MAXW), .RW(RW)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .cmp_ge     (cmp_ge),
        .res        (scan_res),
        .trial_code (trial_code),
        .acc_next   (acc_next),
        .last       (last)
    );

    // next-state and sequencing strobes
    always_comb begin
        state_nx = state;
        ch_nx    = ch;
        accept   = 1'b0;
        done_set = 1'b0;
        res_we   = 1'b0;
        load     = 1'b0;
        step     = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (!pd_q) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (pd_q) begin
                    state_nx = ST_OFF;
                end else if (start_req && first_found) begin
                    accept   = 1'b1;
                    ch_nx    = first_idx;
                    state_nx = ST_SAMPLE;
                end
            end
            ST_SAMPLE: begin
                if (pd_q)          state_nx = ST_OFF;
                else if (stop_req) state_nx = ST_IDLE;
                else begin
                    load     = 1'b1;
                    state_nx = ST_TRIAL;
                end
            end
            ST_TRIAL: begin
                if (pd_q)          state_nx = ST_OFF;
                else if (stop_req) state_nx = ST_IDLE;
                else begin
                    step = 1'b1;
                    if (last) begin
                        res_we = 1'b1;
                        if (nxt_found) begin
                            ch_nx    = nxt_idx;
                            state_nx = ST_SAMPLE;
                        end else begin
                            done_set = 1'b1;
                            if (scan_cont && first_found) begin
                                ch_nx    = first_idx;
                                state_nx = ST_SAMPLE;
                            end else begin
                                state_nx = ST_IDLE;
                            end
                        end
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ch    <= '0;
        end else begin
            state <= state_nx;
            ch    <= ch_nx;
        end
    end

    // outputs
    always_comb begin
        busy     = (state == ST_SAMPLE) || (state == ST_TRIAL);
        ana_en   = (state != ST_OFF);
        ana_sel  = ch;
        dac_code = (state == ST_TRIAL) ? trial_code : '0;
        irq      = done_q && ie_q;
    end

    // configuration, scan snapshot and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            res_q     <= RW'(MAXW);
            cont_q    <= 1'b0;
            pd_q      <= 1'b0;
            ie_q      <= 1'b0;
            scan_mask <= '0;
            scan_res  <= RW'(MAXW);
            scan_cont <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q   <= reg_wdata[NCH-1:0];
                res_q  <= clamp_res(reg_wdata[RES_LSB +: RW]);
                cont_q <= reg_wdata[CONT_BIT];
                pd_q   <= reg_wdata[PD_BIT];
                ie_q   <= reg_wdata[IE_BIT];
            end
            if (accept) begin
                scan_mask <= en_q;
                scan_res  <= res_q;
                scan_cont <= cont_q;
            end
            if (done_set)     done_q <= 1'b1;
            else if (clr_req) done_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_result
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           res_q_arr[g] <= '0;
            else if (res_we && (ch == CW'(g)))    res_q_arr[g] <= acc_next;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[AW-1]) begin
            reg_rdata = DW'(res_q_arr[reg_addr[CW-1:0]]);
        end else if (reg_addr == ADDR_CTRL) begin
            reg_rdata = DW'({ie_q, pd_q, cont_q, res_q, en_q});
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata = DW'({busy, done_q});
        end
    end

    // R9: power-down empties the pipeline on the following cycle
    assert_pd_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pd_q |=> (!busy && !ana_en));

    // R6: only enabled channels are ever presented during a scan
    assert_sel_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> scan_mask[ch]);

    // R5: stored results have zero bits below the resolution
    assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> ((acc_next & ((MAXW'(1) << (MAXW - int'(scan_res))) - 1'b1)) == '0));

    // R11: done only rises after a trial cycle finished a pass
    assert_done_from_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state) == ST_TRIAL));

    // R10: an empty mask never leaves idle
    assert_empty_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en_q == '0 && !pd_q) |=> (state == ST_IDLE));

endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd2;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, ana_en, cmp_ge;
    logic [1:0]  ana_sel;
    logic [9:0]  dac_code;
    logic [9:0]  vin [4];
    logic [9:0]  exp_res [4];
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    assign cmp_ge = (vin[ana_sel] >= dac_code);

    adc_scan_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .ana_en(ana_en), .ana_sel(ana_sel), .dac_code(dac_code), .cmp_ge(cmp_ge)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] m, input int r,
                                       input bit cont, input bit pd, input bit ie);
        return {5'b0, ie, pd, cont, 4'(r), m};
    endfunction

    function automatic logic [9:0] trunc(input logic [9:0] v, input int n);
        return (v >> (10 - n)) << (10 - n);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd2; reg_wdata = '0;
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; #1;
        d = reg_rdata;
        reg_addr = 3'd2; #1;
    endtask

    task automatic check_results(input string tag);
        logic [15:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(3'(4 + i), d);
            chk(d[9:0] == exp_res[i], tag, d, exp_res[i]);
        end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(3'd0, d);
        chk(d == 16'h00A0, "R12 ctrl reset", d, 16'h00A0);
        rd(3'd2, d);
        chk(d == 16'h0, "R12 status reset", d, 0);
        chk(ana_en == 1'b1 && irq == 1'b0 && dac_code == '0, "R12 outputs reset",
            {ana_en, irq, dac_code}, 12'h800);
    endtask

    // single pass; field is the written resolution, n the effective one
    task automatic t_single(input logic [3:0] m, input int field, input int n);
        int cnt = 0;
        int conv = 0;
        logic [1:0] seen [4];
        logic [15:0] d;
        wr(3'd0, mk(m, field, 1'b0, 1'b0, 1'b0));
        rd(3'd0, d);
        chk(int'(d[7:4]) == n, "R2 resolution readback", d[7:4], n);
        wr(3'd1, 16'h1);
        while (reg_rdata[1] && cnt < 4000) begin
            if (cnt % (n + 1) == 0 && conv < 4) begin
                seen[conv] = ana_sel;
                conv++;
            end
            cnt++;
            @(negedge clk); #1;
        end
        chk(cnt == $countones(m) * (n + 1), "R3 busy cycles per pass", cnt,
            $countones(m) * (n + 1));
        begin
            int k = 0;
            for (int c = 0; c < 4; c++) begin
                if (m[c]) begin
                    chk(seen[k] == 2'(c), "R6 R1 ascending channel order", seen[k], c);
                    exp_res[c] = trunc(vin[c], n);
                    k++;
                end
            end
        end
        check_results("R4 R5 R6 stored results");
        rd(3'd2, d);
        chk(d[1] == 1'b0, "R7 idle after single pass", d[1], 0);
    endtask

    task automatic t_empty;
        wr(3'd0, mk(4'b0000, 10, 1'b0, 1'b0, 1'b0));
        wr(3'd1, 16'h1);
        chk(reg_rdata[1] == 1'b0, "R10 start with empty mask", reg_rdata[1], 0);
        @(negedge clk); #1;
        chk(reg_rdata[1] == 1'b0, "R10 still idle", reg_rdata[1], 0);
    endtask

    task automatic t_power;
        wr(3'd0, mk(4'b1111, 10, 1'b0, 1'b0, 1'b0));
        wr(3'd1, 16'h1);
        repeat (3) @(negedge clk);
        wr(3'd0, mk(4'b1111, 10, 1'b0, 1'b1, 1'b0));
        @(negedge clk); #1;
        chk(reg_rdata[1] == 1'b0, "R9 conversion halted", reg_rdata[1], 0);
        chk(ana_en == 1'b0, "R9 analog enable low", ana_en, 0);
        wr(3'd1, 16'h1);
        @(negedge clk); #1;
        chk(reg_rdata[1] == 1'b0 && ana_en == 1'b0, "R9 start ignored",
            {reg_rdata[1], ana_en}, 0);
        check_results("R9 results untouched");
        wr(3'd0, mk(4'b1111, 10, 1'b0, 1'b0, 1'b0));
        @(negedge clk); #1;
        chk(ana_en == 1'b1, "R9 analog enable restored", ana_en, 1);
    endtask

    task automatic t_cont;
        logic [15:0] d;
        vin[1] = 10'h2A5;
        wr(3'd0, mk(4'b0010, 3, 1'b1, 1'b0, 1'b0));
        wr(3'd1, 16'h1);
        repeat (20) @(negedge clk); #1;
        chk(reg_rdata[1] == 1'b1, "R8 still scanning", reg_rdata[1], 1);
        rd(3'd5, d);
        chk(d[9:0] == trunc(10'h2A5, 3), "R8 first value", d, trunc(10'h2A5, 3));
        vin[1] = 10'h155;
        repeat (20) @(negedge clk); #1;
        rd(3'd5, d);
        chk(d[9:0] == trunc(10'h155, 3), "R8 value refreshed", d, trunc(10'h155, 3));
        exp_res[1] = trunc(10'h155, 3);
        wr(3'd1, 16'h2);
        chk(reg_rdata[1] == 1'b0, "R8 stop returns idle", reg_rdata[1], 0);
        chk(reg_rdata[0] == 1'b1, "R11 done after repeating passes", reg_rdata[0], 1);
    endtask

    task automatic t_done;
        wr(3'd2, 16'h1);
        chk(reg_rdata[0] == 1'b0, "R11 write-one clears", reg_rdata[0], 0);
        vin[0] = 10'h3C7;
        wr(3'd0, mk(4'b0001, 4, 1'b0, 1'b0, 1'b1));
        wr(3'd1, 16'h1);
        repeat (4) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd2; reg_wdata = '0;
        #1;
        chk(reg_rdata[1] == 1'b0, "R3 pass ended on collision edge", reg_rdata[1], 0);
        chk(reg_rdata[0] == 1'b1, "R11 set wins over clear", reg_rdata[0], 1);
        chk(irq == 1'b1, "R11 irq with enable", irq, 1);
        exp_res[0] = trunc(10'h3C7, 4);
        check_results("R11 R4 collision result");
        wr(3'd2, 16'h1);
        chk(reg_rdata[0] == 1'b0 && irq == 1'b0, "R11 plain clear", {reg_rdata[0], irq}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vin[0] = 10'h3FF; vin[1] = 10'h201; vin[2] = 10'h0F3; vin[3] = 10'h000;
        for (int i = 0; i < 4; i++) exp_res[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_single(4'b1111, 10, 10);
        vin[0] = 10'h1AB; vin[2] = 10'h2CE;
        t_single(4'b0101, 2, 2);
        vin[1] = 10'h37D; vin[3] = 10'h16E;
        t_single(4'b1010, 7, 7);
        vin[2] = 10'h0B9;
        t_single(4'b0100, 15, 10);
        vin[3] = 10'h2FF;
        t_single(4'b1000, 1, 2);
        t_empty;
        t_power;
        t_cont;
        t_done;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule